// File: doc/BRIEF.md
# Comparator Output Event Controller

This block post-processes the single-bit result of an external analog comparator. It takes the raw bit and can optionally invert it. The bit then passes through a flop synchronizer. The synchronized level goes to an edge detector that watches for rising, falling or either transitions. A detected transition sets a sticky edge flag. A status read clears the flag. The flag, gated by a mask bit, drives an interrupt line. A fault output can follow either the edge flag or the processed comparator level, or it can be held low.

Software programs the block through a small 32-bit register port: byte address, write strobe, read strobe, write data and combinational read data. The input-select fields and the bias/hysteresis field do not change the logic here. They are stored and exported on configuration outputs for the analog macro. A key-guarded protection bit can lock the mode and bias registers against writes. Each blocked write is recorded in a violation bit that clears on read.

The register offsets are: control 0x00, mode 0x04, mask-set 0x08, mask-clear 0x0C, mask 0x10, status 0x14, bias 0x18, protect 0x1C, protect-status 0x20, version 0x24.

Top module: `cmp_event_ctrl`

## Requirements
- R1: After reset, every readable register reads 0 except version, which reads the VERSION parameter. After reset, irq and fault are 0.
- R2: The comparator bit, XORed with the mode invert bit (mode bit 12), passes through SYNC_STAGES flops. Status bit 1 reports the flop output as the synchronized level.
- R3: An edge is found by comparing the synchronized level with its value one cycle earlier. Mode bits 10:9 select the edge kind: 0 = rising, 1 = falling, 2 = either, 3 = none. A selected edge sets the edge flag (status bit 0) on the next clock.
- R4: A status read clears the edge flag. An edge detected in the same cycle as the read wins, and the flag stays set.
- R5: The mask bit is set by a write with bit 0 = 1 to mask-set, and cleared by a write with bit 0 = 1 to mask-clear. It reads back as mask bit 0. irq is high exactly when the edge flag and the mask bit are both 1.
- R6: While comparator enable (mode bit 8) is 0, no edge sets the edge flag.
- R7: Fault enable is mode bit 14 and fault source is mode bit 13. When fault enable is 0, fault is 0. Otherwise fault follows the edge flag (source 0) or the synchronized level (source 1).
- R8: While protection is on, writes to mode or bias leave those registers unchanged. Each such write sets protect-status bit 0. A read of protect-status clears that bit.
- R9: A write to protect with bits 31:8 = 0x414343 loads the protection bit from data bit 0. Any other key leaves it unchanged. Protect reads back the protection bit in bit 0.
- R10: After an accepted mode write, edges are ignored for SYNC_STAGES+1 cycles. This covers an invert change while it is still inside the synchronizer.
- R11: A control write with bit 0 = 1 returns every register and all pipeline state to the reset values on that clock.
- R12: Mode bits 2:0 drive minus_sel, bits 6:4 drive plus_sel and bit 8 drives cmp_on. Bias bits BIAS_W-1:0 drive bias_cfg. Mode reads back with all other bits at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw | input | 1 | Raw comparator bit, asynchronous |
| addr | input | ADDR_W | Register byte address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe, used for the clear-on-read side effects |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the same cycle as rd_en |
| irq | output | 1 | Edge flag AND mask |
| fault | output | 1 | Selected fault source, or 0 |
| minus_sel | output | 3 | Stored minus-input select |
| plus_sel | output | 3 | Stored plus-input select |
| cmp_on | output | 1 | Stored comparator enable |
| bias_cfg | output | BIAS_W | Stored bias/hysteresis setting |

## Verification
The bench places a status read in the same cycle as a fresh edge. A design where the clear beats the set would lose that edge, and irq would never rise. It flips the invert bit while the comparator input is steady. A blanking window shorter than the synchronizer depth would report an edge that never happened. It also writes protect with wrong keys and writes mode and bias while protection is on. A design that checked the key loosely would toggle the lock, and a design that dropped the violation bit would read 0 from protect-status.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;

   typedef enum logic [1:0] {
      EDGE_RISE = 2'd0,
      EDGE_FALL = 2'd1,
      EDGE_ANY  = 2'd2,
      EDGE_NONE = 2'd3
   } edge_sel_e;

   typedef struct packed {
      logic       fault_en;
      logic       fault_src;
      logic       invert;
      edge_sel_e  edge_sel;
      logic       cmp_on;
      logic [2:0] plus_sel;
      logic [2:0] minus_sel;
   } mode_t;

   localparam logic [7:0] OFF_CTRL   = 8'h00;
   localparam logic [7:0] OFF_MODE   = 8'h04;
   localparam logic [7:0] OFF_MSET   = 8'h08;
   localparam logic [7:0] OFF_MCLR   = 8'h0C;
   localparam logic [7:0] OFF_MASK   = 8'h10;
   localparam logic [7:0] OFF_STAT   = 8'h14;
   localparam logic [7:0] OFF_BIAS   = 8'h18;
   localparam logic [7:0] OFF_PROT   = 8'h1C;
   localparam logic [7:0] OFF_PSTAT  = 8'h20;
   localparam logic [7:0] OFF_VER    = 8'h24;

   localparam logic [23:0] PROT_KEY  = 24'h414343;

   function automatic mode_t word_to_mode(input logic [31:0] w);
      mode_t m;
      m.minus_sel = w[2:0];
      m.plus_sel  = w[6:4];
      m.cmp_on    = w[8];
      m.edge_sel  = edge_sel_e'(w[10:9]);
      m.invert    = w[12];
      m.fault_src = w[13];
      m.fault_en  = w[14];
      return m;
   endfunction

   function automatic logic [31:0] mode_to_word(input mode_t m);
      logic [31:0] w;
      w        = '0;
      w[2:0]   = m.minus_sel;
      w[6:4]   = m.plus_sel;
      w[8]     = m.cmp_on;
      w[10:9]  = m.edge_sel;
      w[12]    = m.invert;
      w[13]    = m.fault_src;
      w[14]    = m.fault_en;
      return w;
   endfunction

endpackage

// File: rtl/cmp_evt_sync.sv
module cmp_evt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cmp_evt_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic src;
      if (i == 0) begin : g_first
         assign src = d;
      end else begin : g_next
         assign src = chain[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   chain[i] <= 1'b0;
         else if (clr) chain[i] <= 1'b0;
         else          chain[i] <= src;
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/cmp_evt_edge.sv
module cmp_evt_edge
   import cmp_evt_pkg::*;
#(
   parameter int BLANK = 3
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      clr,
   input  logic      level,
   input  edge_sel_e edge_sel,
   input  logic      enable,
   input  logic      reconfig,
   output logic      hit
);
   localparam int CNT_W = $clog2(BLANK + 1);

   if (BLANK < 1) begin : g_bad_blank
      $error("cmp_evt_edge: BLANK must be at least 1");
   end

   logic             prev_q;
   logic [CNT_W-1:0] cnt_q;
   logic             raw_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         cnt_q  <= '0;
      end else if (clr) begin
         prev_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         prev_q <= level;
         if (reconfig)         cnt_q <= CNT_W'(BLANK);
         else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end
   end

   always_comb begin
      case (edge_sel)
         EDGE_RISE: raw_edge = level & ~prev_q;
         EDGE_FALL: raw_edge = ~level & prev_q;
         EDGE_ANY:  raw_edge = level ^ prev_q;
         default:   raw_edge = 1'b0;
      endcase
   end

   assign hit = enable & (cnt_q == '0) & raw_edge;

   // R10: the window right after a reconfiguration never reports an edge
   p_blank_after_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reconfig && !clr) |=> !hit);

endmodule

// File: rtl/cmp_evt_flag.sv
module cmp_evt_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic hit,
   input  logic rd_clr,
   input  logic mask,
   input  logic fault_en,
   input  logic fault_src,
   input  logic level,
   output logic flag,
   output logic irq,
   output logic fault
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (clr) flag <= 1'b0;
      else          flag <= (flag & ~rd_clr) | hit;
   end

   assign irq   = flag & mask;
   assign fault = fault_en & (fault_src ? level : flag);

   // R4: a read with no concurrent edge leaves the flag clear
   p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !hit && !clr) |=> !flag);
   // R3/R4: a detected edge is always recorded, even against a read
   p_hit_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !clr) |=> flag);

endmodule

// File: rtl/cmp_event_ctrl.sv
module cmp_event_ctrl
   import cmp_evt_pkg::*;
#(
   parameter int          ADDR_W      = 8,
   parameter int          SYNC_STAGES = 2,
   parameter int          BIAS_W      = 3,
   parameter logic [31:0] VERSION     = 32'h0000_0110
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp_raw,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic              irq,
   output logic              fault,
   output logic [2:0]        minus_sel,
   output logic [2:0]        plus_sel,
   output logic              cmp_on,
   output logic [BIAS_W-1:0] bias_cfg
);
   localparam int BLANK = SYNC_STAGES + 1;

   if (ADDR_W < 6) begin : g_bad_addr
      $error("cmp_event_ctrl: ADDR_W must cover the register map");
   end
   if (BIAS_W < 1 || BIAS_W > 8) begin : g_bad_bias
      $error("cmp_event_ctrl: BIAS_W must be 1..8");
   end

   mode_t             mode_q;
   logic [BIAS_W-1:0] bias_q;
   logic              mask_q, prot_q, viol_q;
   logic              level, hit, flag;

   logic a_ctrl, a_mode, a_mset, a_mclr, a_stat, a_bias, a_prot, a_pstat;
   assign a_ctrl  = addr == ADDR_W'(OFF_CTRL);
   assign a_mode  = addr == ADDR_W'(OFF_MODE);
   assign a_mset  = addr == ADDR_W'(OFF_MSET);
   assign a_mclr  = addr == ADDR_W'(OFF_MCLR);
   assign a_stat  = addr == ADDR_W'(OFF_STAT);
   assign a_bias  = addr == ADDR_W'(OFF_BIAS);
   assign a_prot  = addr == ADDR_W'(OFF_PROT);
   assign a_pstat = addr == ADDR_W'(OFF_PSTAT);

   logic sw_rst, mode_wr, bias_wr, cfg_blocked, key_ok;
   assign sw_rst      = wr_en & a_ctrl & wdata[0];
   assign mode_wr     = wr_en & a_mode & ~prot_q;
   assign bias_wr     = wr_en & a_bias & ~prot_q;
   assign cfg_blocked = wr_en & (a_mode | a_bias) & prot_q;
   assign key_ok      = wdata[31:8] == PROT_KEY;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         bias_q <= '0;
         mask_q <= 1'b0;
         prot_q <= 1'b0;
         viol_q <= 1'b0;
      end else if (sw_rst) begin
         mode_q <= '0;
         bias_q <= '0;
         mask_q <= 1'b0;
         prot_q <= 1'b0;
         viol_q <= 1'b0;
      end else begin
         if (mode_wr) mode_q <= word_to_mode(wdata);
         if (bias_wr) bias_q <= wdata[BIAS_W-1:0];
         if (wr_en & a_mset & wdata[0])      mask_q <= 1'b1;
         else if (wr_en & a_mclr & wdata[0]) mask_q <= 1'b0;
         if (wr_en & a_prot & key_ok) prot_q <= wdata[0];
         if (cfg_blocked)             viol_q <= 1'b1;
         else if (rd_en & a_pstat)    viol_q <= 1'b0;
      end
   end

   cmp_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .clr(sw_rst),
      .d(cmp_raw ^ mode_q.invert), .q(level)
   );

   cmp_evt_edge #(.BLANK(BLANK)) u_edge (
      .clk(clk), .rst_n(rst_n), .clr(sw_rst), .level(level),
      .edge_sel(mode_q.edge_sel), .enable(mode_q.cmp_on),
      .reconfig(mode_wr), .hit(hit)
   );

   cmp_evt_flag u_flag (
      .clk(clk), .rst_n(rst_n), .clr(sw_rst), .hit(hit),
      .rd_clr(rd_en & a_stat), .mask(mask_q),
      .fault_en(mode_q.fault_en), .fault_src(mode_q.fault_src),
      .level(level), .flag(flag), .irq(irq), .fault(fault)
   );

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         case (addr)
            ADDR_W'(OFF_MODE):  rdata = mode_to_word(mode_q);
            ADDR_W'(OFF_MASK):  rdata[0] = mask_q;
            ADDR_W'(OFF_STAT):  rdata[1:0] = {level, flag};
            ADDR_W'(OFF_BIAS):  rdata[BIAS_W-1:0] = bias_q;
            ADDR_W'(OFF_PROT):  rdata[0] = prot_q;
            ADDR_W'(OFF_PSTAT): rdata[0] = viol_q;
            ADDR_W'(OFF_VER):   rdata = VERSION;
            default:            rdata = '0;
         endcase
      end
   end

   assign minus_sel = mode_q.minus_sel;
   assign plus_sel  = mode_q.plus_sel;
   assign cmp_on    = mode_q.cmp_on;
   assign bias_cfg  = bias_q;

   // R6: a disabled comparator never raises the edge flag
   p_off_no_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q.cmp_on |=> !$rose(flag));
   // R8: protected mode writes leave mode unchanged
   p_prot_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_q && wr_en && a_mode) |=> $stable(mode_q));
   // R8: every blocked write is recorded
   p_prot_viol_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_q && wr_en && (a_mode || a_bias)) |=> viol_q);
   // R9: a wrong key never changes protection
   p_bad_key_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && a_prot && !key_ok) |=> $stable(prot_q));
   // R11: software reset clears mode, mask and irq
   p_swrst_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rst |=> (mode_q == mode_t'('0) && !mask_q && !irq));
   // R5: an unmasked flag rise shows on irq
   p_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(flag) && mask_q) |-> irq);

endmodule

// File: tb/cmp_event_ctrl_tb_top.sv
module cmp_event_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] A_CTRL = 8'h00, A_MODE = 8'h04, A_MSET = 8'h08,
      A_MCLR = 8'h0C, A_MASK = 8'h10, A_STAT = 8'h14, A_BIAS = 8'h18,
      A_PROT = 8'h1C, A_PSTAT = 8'h20, A_VER = 8'h24;
   localparam logic [23:0] KEY = 24'h414343;
   localparam logic [31:0] VER = 32'h0000_0110;

   logic clk = 1'b0, rst_n = 1'b0, cmp_raw = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] addr = '0;
   logic [31:0] wdata = '0, rdata;
   logic irq, fault, cmp_on;
   logic [2:0] minus_sel, plus_sel, bias_cfg;

   int checks = 0, errors = 0;
   bit done = 0;
   bit cur_raw = 0;

   // reference state derived from the requirements
   bit m_s1, m_s2, m_prev, m_flag, m_mask, m_prot, m_viol;
   int m_cnt;
   logic [31:0] m_mode;
   logic [2:0]  m_bias;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmp_event_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .addr(addr),
      .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
      .irq(irq), .fault(fault), .minus_sel(minus_sel), .plus_sel(plus_sel),
      .cmp_on(cmp_on), .bias_cfg(bias_cfg)
   );

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic m_clear();
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_flag = 0; m_mask = 0;
      m_prot = 0; m_viol = 0; m_cnt = 0; m_mode = '0; m_bias = '0;
   endtask

   function automatic logic [31:0] exp_rd(input logic [7:0] a);
      case (a)
         A_MODE:  return m_mode;
         A_MASK:  return {31'b0, m_mask};
         A_STAT:  return {30'b0, m_s2, m_flag};
         A_BIAS:  return {29'b0, m_bias};
         A_PROT:  return {31'b0, m_prot};
         A_PSTAT: return {31'b0, m_viol};
         A_VER:   return VER;
         default: return 32'h0;
      endcase
   endfunction

   function automatic bit exp_fault();
      if (!m_mode[14]) return 1'b0;
      return m_mode[13] ? m_s2 : m_flag;
   endfunction

   task automatic cyc(input bit wr, input bit rd, input logic [7:0] a,
                      input logic [31:0] d, input string tag);
      bit er, hit, srst, n_s1;
      @(negedge clk);
      cmp_raw = cur_raw; wr_en = wr; rd_en = rd; addr = a; wdata = d;
      #1;
      if (rd) chk(tag, "rdata", rdata, exp_rd(a));
      @(posedge clk);
      case (m_mode[10:9])
         2'd0: er = m_s2 & ~m_prev;
         2'd1: er = ~m_s2 & m_prev;
         2'd2: er = m_s2 ^ m_prev;
         default: er = 1'b0;
      endcase
      hit  = m_mode[8] && (m_cnt == 0) && er;
      srst = wr && a == A_CTRL && d[0];
      if (srst) m_clear();
      else begin
         n_s1 = cur_raw ^ m_mode[12];
         m_prev = m_s2; m_s2 = m_s1; m_s1 = n_s1;
         m_flag = (m_flag & ~(rd && a == A_STAT)) | hit;
         if (wr && a == A_MODE && !m_prot) m_cnt = 3;
         else if (m_cnt != 0) m_cnt--;
         if (wr && a == A_MSET && d[0]) m_mask = 1;
         else if (wr && a == A_MCLR && d[0]) m_mask = 0;
         if (wr && (a == A_MODE || a == A_BIAS) && m_prot) m_viol = 1;
         else if (rd && a == A_PSTAT) m_viol = 0;
         if (wr && a == A_MODE && !m_prot) m_mode = d & 32'h0000_7777;
         if (wr && a == A_BIAS && !m_prot) m_bias = d[2:0];
         if (wr && a == A_PROT && d[31:8] == KEY) m_prot = d[0];
      end
      #1;
      chk(tag, "irq", {31'b0, irq}, {31'b0, m_flag & m_mask});
      chk(tag, "fault", {31'b0, fault}, {31'b0, exp_fault()});
      chk(tag, "cfg", {22'b0, minus_sel, plus_sel, cmp_on, bias_cfg},
          {22'b0, m_mode[2:0], m_mode[6:4], m_mode[8], m_bias});
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [31:0] d, input string tag);
      cyc(1, 0, a, d, tag);
   endtask
   task automatic rd_reg(input logic [7:0] a, input string tag);
      cyc(0, 1, a, 32'h0, tag);
   endtask
   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 32'h0, tag);
   endtask

   function automatic logic [31:0] mk_mode(input bit en, input logic [1:0] typ,
         input bit inv, input bit fsrc, input bit fen);
      return {17'b0, fen, fsrc, inv, 1'b0, typ, en, 8'h25};
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      m_clear();
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R1 reset values
      chk("R1", "irq", {31'b0, irq}, 32'h0);
      chk("R1", "fault", {31'b0, fault}, 32'h0);
      rd_reg(A_MODE, "R1"); rd_reg(A_STAT, "R1"); rd_reg(A_MASK, "R1");
      rd_reg(A_VER, "R1"); rd_reg(A_PROT, "R1");
      // R12 config export and readback
      wr_reg(A_BIAS, 32'hFFFF_FFFD, "R12"); rd_reg(A_BIAS, "R12");
      wr_reg(A_MODE, 32'hFFFF_FFFF, "R12"); rd_reg(A_MODE, "R12");
      // R3 rising edges, R5 mask
      wr_reg(A_MODE, mk_mode(1, 2'd0, 0, 0, 0), "R3"); idle(4, "R3");
      wr_reg(A_MSET, 32'h1, "R5"); rd_reg(A_MASK, "R5");
      cur_raw = 1; idle(4, "R3"); rd_reg(A_STAT, "R3"); rd_reg(A_STAT, "R4");
      cur_raw = 0; idle(4, "R3"); rd_reg(A_STAT, "R3");
      // R4 read in the same cycle as the edge
      cur_raw = 1; idle(2, "R4"); rd_reg(A_STAT, "R4"); rd_reg(A_STAT, "R4");
      // R3 falling and any
      wr_reg(A_MODE, mk_mode(1, 2'd1, 0, 0, 0), "R3"); idle(4, "R3");
      cur_raw = 0; idle(4, "R3"); rd_reg(A_STAT, "R3");
      wr_reg(A_MODE, mk_mode(1, 2'd2, 0, 0, 0), "R3"); idle(4, "R3");
      cur_raw = 1; idle(4, "R3"); rd_reg(A_STAT, "R3");
      cur_raw = 0; idle(4, "R3"); rd_reg(A_STAT, "R3");
      wr_reg(A_MODE, mk_mode(1, 2'd3, 0, 0, 0), "R3");
      cur_raw = 1; idle(5, "R3"); rd_reg(A_STAT, "R3");
      // R6 disabled comparator
      wr_reg(A_MODE, mk_mode(0, 2'd2, 0, 0, 0), "R6");
      cur_raw = 0; idle(5, "R6"); rd_reg(A_STAT, "R6");
      // R2 and R10 invert change while input steady
      wr_reg(A_MODE, mk_mode(1, 2'd2, 1, 0, 0), "R10"); idle(6, "R10");
      rd_reg(A_STAT, "R10"); rd_reg(A_STAT, "R2");
      // R7 fault sources
      wr_reg(A_MODE, mk_mode(1, 2'd2, 1, 1, 1), "R7"); idle(4, "R7");
      cur_raw = 1; idle(4, "R7");
      wr_reg(A_MODE, mk_mode(1, 2'd2, 0, 0, 1), "R7");
      cur_raw = 0; idle(4, "R7"); rd_reg(A_STAT, "R7"); idle(1, "R7");
      wr_reg(A_MCLR, 32'h1, "R5"); rd_reg(A_MASK, "R5");
      // R9 keys, R8 blocked writes
      wr_reg(A_PROT, {24'h414344, 8'h01}, "R9"); rd_reg(A_PROT, "R9");
      wr_reg(A_PROT, {KEY, 8'h01}, "R9"); rd_reg(A_PROT, "R9");
      wr_reg(A_MODE, 32'h0000_0000, "R8"); rd_reg(A_MODE, "R8");
      wr_reg(A_BIAS, 32'h0, "R8"); rd_reg(A_BIAS, "R8");
      rd_reg(A_PSTAT, "R8"); rd_reg(A_PSTAT, "R8");
      wr_reg(A_PROT, {24'h0, 8'h00}, "R9"); rd_reg(A_PROT, "R9");
      wr_reg(A_PROT, {KEY, 8'h00}, "R9"); rd_reg(A_PROT, "R9");
      // R11 software reset
      wr_reg(A_MSET, 32'h1, "R11"); cur_raw = 1; idle(4, "R11");
      wr_reg(A_CTRL, 32'h1, "R11");
      rd_reg(A_MODE, "R11"); rd_reg(A_STAT, "R11"); rd_reg(A_MASK, "R11");
      // random phase
      for (int n = 0; n < 4000; n++) begin
         int op;
         if ($urandom % 4 == 0) cur_raw = ~cur_raw;
         op = $urandom % 20;
         case (op)
            0, 1, 2: rd_reg(A_STAT, "R4");
            3: wr_reg(A_MODE, $urandom, "R3");
            4: wr_reg(A_MSET, $urandom, "R5");
            5: wr_reg(A_MCLR, $urandom, "R5");
            6: rd_reg(A_PSTAT, "R8");
            7: wr_reg(A_PROT, {($urandom % 2) ? KEY : 24'($urandom), 7'b0, 1'($urandom)}, "R9");
            8: wr_reg(A_BIAS, $urandom, "R12");
            9: rd_reg(8'($urandom % 10) << 2, "R12");
            10: if ($urandom % 32 == 0) wr_reg(A_CTRL, 32'h1, "R11");
                else idle(1, "R2");
            default: idle(1, "R7");
         endcase
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule